// File: doc/BRIEF.md
# Button-Driven Three-Channel Attenuator Programmer

This block programs a three-channel audio attenuator over a three-wire serial link (an active-low load strobe, a serial clock and a serial data line), with no processor involved. It holds one 8-bit attenuation level for each of three channels and an index that points at the channel currently being adjusted. Three pushbuttons drive it: one raises the level of the selected channel, one lowers it, and one moves the selection to the next channel.

Each button is synchronised and debounced, and only its press edge acts. When a press changes a level, the block shifts out one 16-bit word. The first eight bits carry the channel address and the last eight carry the new level, most significant bit first. The load strobe frames the word, and `busy` is high while the word is on the wire. Presses that arrive while a word is being sent are dropped.

Top module: `atten_prog`

## Requirements
- R1: After reset, `load_n` is 1, `ser_clk` is 0, `ser_data` is 0 and `busy` is 0. All three levels are 0 and channel 0 is selected.
- R2: During a frame, `load_n` is low from the start to the end. Exactly 16 rising edges of `ser_clk` occur in that time, and none occur while `load_n` is high.
- R3: Word bit 15 is sent first and bit 0 last. Bits 15..8 hold the channel address, coded as 0, 1 or 2, and bits 7..0 hold the new level of that channel.
- R4: `ser_data` changes only while `ser_clk` is low. Each half period of `ser_clk` lasts DIV_HALF system clocks. The first rising edge comes DIV_HALF clocks after `load_n` falls. `load_n` rises DIV_HALF clocks after the 16th rising edge, in the same cycle that `ser_clk` falls.
- R5: A press of the up button adds 1 to the level of the selected channel. A press of the down button subtracts 1. Each such change sends exactly one frame.
- R6: The level saturates at 255 and at 0. An up press at 255 or a down press at 0 leaves the level unchanged and sends no frame.
- R7: A press of the select button steps the selection 0 → 1 → 2 → 0 and sends no frame.
- R8: A button acts only after its input has held a new level for DEB_CYCLES consecutive clocks. A shorter pulse has no effect. Holding a button acts once per press.
- R9: A press whose debounced edge falls while `busy` is high, or in the cycle a frame is launched, is discarded. It changes no level and sends no frame.
- R10: Each channel keeps its own level, and changing one channel leaves the others untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_up | input | 1 | Raw up pushbutton, active high |
| btn_down | input | 1 | Raw down pushbutton, active high |
| btn_sel | input | 1 | Raw channel-select pushbutton, active high |
| load_n | output | 1 | Frame strobe, low during a transfer |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, valid on rising `ser_clk` |
| busy | output | 1 | High while a frame is being shifted |

## Verification
The bound checker checks the wire protocol on every cycle. It confirms the idle levels whenever `busy` is low and that `ser_clk` toggles only inside a load window. It confirms that data holds steady while the serial clock is high, that each frame closes after 16 rising edges, and that the load strobe rises together with a falling serial clock. The button-level behaviour can only be shown by the bench's scenarios, which compare captured words against values computed from the press history. That behaviour covers saturation at both ends, selection wrap-around, independence of the channel levels, rejection of glitches and of held buttons, and discarding of presses during a transfer.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int LEVEL_W  = 8;
    localparam int ADDR_W   = 8;
    localparam int NUM_CH   = 3;
    localparam int CH_IDX_W = $clog2(NUM_CH);
    localparam int WORD_W   = ADDR_W + LEVEL_W;

    typedef logic [LEVEL_W-1:0]  level_t;
    typedef logic [CH_IDX_W-1:0] ch_idx_t;

    localparam level_t LEVEL_MAX = '1;
    localparam level_t LEVEL_MIN = '0;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_UP,
        ACT_DOWN,
        ACT_SEL
    } action_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        level_t            level;
    } word_t;

    // Only one button acts per cycle: up, then down, then select.
    function automatic action_e pick_action(input logic up, input logic dn,
                                            input logic sel, input logic blocked);
        if (blocked)  return ACT_NONE;
        if (up)       return ACT_UP;
        if (dn)       return ACT_DOWN;
        if (sel)      return ACT_SEL;
        return ACT_NONE;
    endfunction

    function automatic ch_idx_t step_channel(input ch_idx_t cur);
        if (cur == ch_idx_t'(NUM_CH - 1)) return '0;
        return cur + ch_idx_t'(1);
    endfunction

endpackage

// File: rtl/ap_debounce.sv
module ap_debounce #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic press_o
);
    localparam int CNT_W = $clog2(DEB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    logic             sync_a, sync_b;
    logic             stable_q, stable_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a   <= 1'b0;
            sync_b   <= 1'b0;
            stable_q <= 1'b0;
            stable_d <= 1'b0;
            cnt_q    <= '0;
        end else begin
            sync_a   <= raw_i;
            sync_b   <= sync_a;
            stable_d <= stable_q;
            if (sync_b == stable_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
                stable_q <= sync_b;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign press_o = stable_q & ~stable_d;

endmodule

// File: rtl/ap_settings.sv
module ap_settings
    import atten_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  press_up,
    input  logic  press_dn,
    input  logic  press_sel,
    input  logic  xfer_busy,
    output logic  start_o,
    output word_t word_o
);
    level_t  level_q [NUM_CH];
    ch_idx_t chan_q;
    action_e act;
    level_t  cur_level, next_level;
    logic    write_en;

    assign act       = pick_action(press_up, press_dn, press_sel, xfer_busy | start_o);
    assign cur_level = level_q[chan_q];

    always_comb begin
        next_level = cur_level;
        write_en   = 1'b0;
        unique case (act)
            ACT_UP: begin
                next_level = cur_level + level_t'(1);
                write_en   = (cur_level != LEVEL_MAX);
            end
            ACT_DOWN: begin
                next_level = cur_level - level_t'(1);
                write_en   = (cur_level != LEVEL_MIN);
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst)
                level_q[g] <= LEVEL_MIN;
            else if (write_en && chan_q == ch_idx_t'(g))
                level_q[g] <= next_level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q  <= '0;
            start_o <= 1'b0;
            word_o  <= '0;
        end else begin
            start_o <= write_en;
            if (act == ACT_SEL)
                chan_q <= step_channel(chan_q);
            if (write_en)
                word_o <= '{addr: ADDR_W'(chan_q), level: next_level};
        end
    end

endmodule

// File: rtl/ap_shifter.sv
module ap_shifter
    import atten_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  word_t word_i,
    output logic  load_n,
    output logic  ser_clk,
    output logic  ser_data,
    output logic  busy
);
    localparam int DIV_W = $clog2(DIV_HALF + 1);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_state_e;

    sh_state_e         state_q;
    logic [WORD_W-1:0] shreg_q;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;
    logic              half_done;

    assign half_done = (div_q == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            shreg_q <= '0;
            div_q   <= '0;
            bit_q   <= '0;
            load_n  <= 1'b1;
            ser_clk <= 1'b0;
        end else begin
            unique case (state_q)
                SH_IDLE: begin
                    if (start_i) begin
                        shreg_q <= word_i;
                        load_n  <= 1'b0;
                        div_q   <= '0;
                        bit_q   <= '0;
                        state_q <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (half_done) begin
                        div_q   <= '0;
                        ser_clk <= 1'b1;
                        state_q <= SH_HIGH;
                    end else begin
                        div_q <= div_q + DIV_W'(1);
                    end
                end
                SH_HIGH: begin
                    if (half_done) begin
                        div_q   <= '0;
                        ser_clk <= 1'b0;
                        if (bit_q == BIT_LAST) begin
                            load_n  <= 1'b1;
                            state_q <= SH_IDLE;
                        end else begin
                            bit_q   <= bit_q + BIT_W'(1);
                            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                            state_q <= SH_LOW;
                        end
                    end else begin
                        div_q <= div_q + DIV_W'(1);
                    end
                end
                default: state_q <= SH_IDLE;
            endcase
        end
    end

    assign ser_data = ~load_n & shreg_q[WORD_W-1];
    assign busy     = (state_q != SH_IDLE);

endmodule

// File: rtl/atten_prog.sv
module atten_prog
    import atten_pkg::*;
#(
    parameter int DEB_CYCLES = 16,
    parameter int DIV_HALF   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_up,
    input  logic btn_down,
    input  logic btn_sel,
    output logic load_n,
    output logic ser_clk,
    output logic ser_data,
    output logic busy
);
    localparam int NUM_BTN = 3;

    logic [NUM_BTN-1:0] raw_btn, press;
    logic               start;
    word_t              word;

    assign raw_btn = {btn_sel, btn_down, btn_up};

    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
        ap_debounce #(.DEB_CYCLES(DEB_CYCLES)) i_deb (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (raw_btn[b]),
            .press_o (press[b])
        );
    end

    ap_settings i_set (
        .clk       (clk),
        .rst       (rst),
        .press_up  (press[0]),
        .press_dn  (press[1]),
        .press_sel (press[2]),
        .xfer_busy (busy),
        .start_o   (start),
        .word_o    (word)
    );

    ap_shifter #(.DIV_HALF(DIV_HALF)) i_sh (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .word_i   (word),
        .load_n   (load_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .busy     (busy)
    );

endmodule

// File: rtl/atten_prog_chk.sv
module atten_prog_chk (
    input logic clk,
    input logic rst,
    input logic load_n,
    input logic ser_clk,
    input logic ser_data,
    input logic busy
);
    logic       sclk_q;
    logic [4:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_q <= ser_clk;
            if (load_n)
                rise_cnt <= '0;
            else if (ser_clk && !sclk_q)
                rise_cnt <= rise_cnt + 5'd1;
        end
    end

    // R1: idle levels whenever no transfer is running
    assert_idle_levels_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (load_n && !ser_clk && !ser_data));

    // R2: serial clock only moves inside the load window
    assert_clk_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> !load_n);

    // R2: a frame closes after exactly sixteen rising edges
    assert_sixteen_edges_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(load_n) |-> (rise_cnt == 5'd16));

    // R4: data holds while the serial clock is high
    assert_data_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && sclk_q) |-> $stable(ser_data));

    // R4: load rises together with the last falling serial clock
    assert_load_close_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(load_n) |-> $fell(ser_clk));

endmodule

bind atten_prog atten_prog_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_n   (load_n),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .busy     (busy)
);

// File: tb/test_atten_prog.sv
`timescale 1ns/1ps
module test_atten_prog;
    localparam int DEB  = 8;
    localparam int HALF = 2;
    localparam int HOLD = DEB + 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_up = 1'b0, btn_down = 1'b0, btn_sel = 1'b0;
    logic load_n, ser_clk, ser_data, busy;

    always #2.5 clk = ~clk;

    atten_prog #(.DEB_CYCLES(DEB), .DIV_HALF(HALF)) i_atten_prog (
        .clk(clk), .rst(rst), .btn_up(btn_up), .btn_down(btn_down),
        .btn_sel(btn_sel), .load_n(load_n), .ser_clk(ser_clk),
        .ser_data(ser_data), .busy(busy)
    );

    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // frame monitor
    int    cyc = 0, t_last = 0, edges = 0, nframes = 0, stray = 0;
    bit    first_rise = 0, timing_ok = 1;
    logic  prev_ld = 1'b1, prev_sclk = 1'b0, prev_sd = 1'b0;
    logic [15:0] cap = '0, last_word = '0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (prev_ld && !load_n) begin
                edges = 0; t_last = cyc; timing_ok = 1; first_rise = 1;
            end
            if (!prev_sclk && ser_clk) begin
                if (load_n) stray++;
                cap = {cap[14:0], ser_data};
                edges++;
                if (cyc - t_last != (first_rise ? HALF : 2*HALF)) timing_ok = 0;
                t_last = cyc; first_rise = 0;
            end
            if (prev_sclk && ser_clk && ser_data != prev_sd) timing_ok = 0;
            if (!prev_ld && load_n) begin
                if (cyc - t_last != HALF || ser_clk) timing_ok = 0;
                chk(edges == 16 && stray == 0, "R2 edge count in frame", edges, 16);
                chk(timing_ok, "R4 serial timing", 0, 1);
                last_word = cap;
                nframes++;
            end
        end
        prev_ld = load_n; prev_sclk = ser_clk; prev_sd = ser_data;
    end

    task automatic settle();
        repeat (4) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // 0 = up, 1 = down, 2 = select
    task automatic press(input int which, input int hold);
        if (which == 0) btn_up = 1'b1; else if (which == 1) btn_down = 1'b1; else btn_sel = 1'b1;
        repeat (hold) @(negedge clk);
        btn_up = 1'b0; btn_down = 1'b0; btn_sel = 1'b0;
        repeat (HOLD) @(negedge clk);
        settle();
    endtask

    task automatic press_expect(input int which, input logic [15:0] exp, input string tag);
        int n0 = nframes;
        press(which, HOLD);
        chk(nframes == n0 + 1, {tag, " frame count"}, nframes - n0, 1);
        chk(last_word == exp, {tag, " word"}, last_word, exp);
    endtask

    task automatic press_none(input int which, input int hold, input string tag);
        int n0 = nframes;
        press(which, hold);
        chk(nframes == n0, tag, nframes - n0, 0);
    endtask

    task automatic t_reset();
        chk(load_n == 1'b1 && ser_clk == 1'b0 && ser_data == 1'b0 && busy == 1'b0,
            "R1 idle outputs", {load_n, ser_clk, ser_data, busy}, 4'b1000);
    endtask

    task automatic t_basic();
        press_none(1, HOLD, "R6 down at zero");
        press_expect(0, 16'h0001, "R5 R3 up ch0");
        press_expect(0, 16'h0002, "R5 up ch0 again");
        press_expect(1, 16'h0001, "R5 down ch0");
    endtask

    task automatic t_select();
        press_none(2, HOLD, "R7 select sends nothing");
        press_expect(0, 16'h0101, "R10 R3 ch1 starts at zero");
        press_none(2, HOLD, "R7 select ch2");
        press_none(1, HOLD, "R6 down at zero ch2");
        press_expect(0, 16'h0201, "R3 ch2 address");
        press_none(2, HOLD, "R7 wrap to ch0");
        press_expect(0, 16'h0002, "R10 R7 ch0 kept its level");
    endtask

    task automatic t_debounce();
        press_none(0, 3, "R8 short glitch ignored");
        press_expect(0, 16'h0003, "R8 after glitch");
        begin
            int n0 = nframes;
            press(0, 150);
            chk(nframes == n0 + 1, "R8 held button acts once", nframes - n0, 1);
            chk(last_word == 16'h0004, "R8 held button word", last_word, 16'h0004);
        end
    endtask

    task automatic t_busy();
        int n0 = nframes;
        btn_up = 1'b1;
        while (!busy) @(negedge clk);
        btn_up = 1'b0;
        btn_down = 1'b1;
        repeat (HOLD) @(negedge clk);
        btn_down = 1'b0;
        chk(busy == 1'b1, "R9 down press inside transfer", busy, 1);
        repeat (HOLD) @(negedge clk);
        settle();
        chk(nframes == n0 + 1, "R9 ignored press sends nothing", nframes - n0, 1);
        chk(last_word == 16'h0005, "R9 first word", last_word, 16'h0005);
        press_expect(0, 16'h0006, "R9 level not lowered");
    endtask

    task automatic t_saturate();
        press_none(2, HOLD, "R7 select ch1");
        for (int i = 0; i < 254; i++) press(0, HOLD);
        chk(last_word == 16'h01FF, "R6 reached max", last_word, 16'h01FF);
        press_none(0, HOLD, "R6 up at max");
        press_expect(1, 16'h01FE, "R6 down from max");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_select();
        t_debounce();
        t_busy();
        t_saturate();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule